// File: doc/BRIEF.md
# Interrupt Coalescing Doorbell Unit

This block decides when one completion queue interrupts the host. It counts the completion events that the queue reports and raises a level interrupt request in one of two cases. The first is that a coarse coalescing timer has run out while events are still pending. The second is that the pending count has reached a packet threshold and the queue has then been quiet for a short inter-packet gap. Software steers the block through a single 32-bit doorbell write. That write can acknowledge serviced events, load a new coalescing timeout and re-arm the engine, or switch interrupt generation off.

Time is measured in half-microsecond ticks. The parameter `TICK_DIV` gives the number of clock cycles in one tick. Ten ticks make one coalescing unit. The packet threshold and the inter-packet gap come from the queue flavour chosen by the parameter `IS_RX`:
- transmit: threshold 12, gap 15 ticks;
- receive: threshold 6, gap 3 ticks.

The controller has three states: `ST_OFF`, `ST_ARMED` and `ST_FIRED`. It moves between them through three transitions:
- ARM: an acknowledge with a nonzero timeout, taken from any state into `ST_ARMED`.
- MUTE: an acknowledge with a zero timeout, or a disable write, taken from any state into `ST_OFF`.
- FIRE: a coalescing or inter-packet condition met while in `ST_ARMED`, taken into `ST_FIRED`.

A doorbell write in the same cycle as a FIRE condition wins over it.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the block is in `ST_OFF` and `irq_o` is low. Events that arrive while the block is off never raise `irq_o`.
- R2: The doorbell fields are as follows. Bit 31 marks an acknowledge. Bits 23:16 carry the coalescing timeout in units. Bits 15:0 carry the number of events acknowledged. Bit 30 without bit 31 is a disable command, and when both bits are set the acknowledge takes priority. A write with neither bit set has no effect.
- R3: An acknowledge with timeout T > 0 arms the block and restarts the coalescing timer. If events are pending, `irq_o` rises exactly T*TICK_DIV*10+1 cycles after the clock edge that captured the write.
- R4: An acknowledge subtracts its count from the pending events and saturates at zero. With nothing pending, expiry of the coalescing timer raises no interrupt.
- R5: Once the coalescing timer has expired in `ST_ARMED`, the next event raises `irq_o` one cycle after the edge that counted that event.
- R6: When the pending count is at or above the threshold and no event has arrived for gap*TICK_DIV cycles, `irq_o` rises one cycle later.
- R7: Each event restarts the inter-packet gap, so an event that arrives inside the gap postpones the interrupt.
- R8: Once raised, `irq_o` stays high through further events and through ignored writes until an acknowledge or a disable write.
- R9: A disable write drops `irq_o` in the next cycle and blocks further interrupts, whatever the pending count.
- R10: An acknowledge with a zero timeout drops `irq_o` in the next cycle, leaves the block off and still subtracts its count.
- R11: Events are counted in every state, so events that arrive while the block is off fire once it is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | 1 | One completion event per cycle when high |
| db_we_i | input | 1 | Doorbell write strobe |
| db_data_i | input | 32 | Doorbell write data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is the inter-packet restart. It needs the pending count to be already at the threshold when one more event lands inside the gap, so that the interrupt moves to a full gap after that late event instead of appearing a few cycles earlier. The stimulus builds this case directly. With a long coalescing timeout armed, it sends exactly threshold events back to back, idles for fewer cycles than the gap, then sends one more event and measures the cycle distance to the rising edge. The same style of cycle measurement also separates acknowledge priority from disable priority when both command bits are written together.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    localparam int DB_W       = 32;
    localparam int ACK_BIT    = 31;
    localparam int OFF_BIT    = 30;
    localparam int TMO_LSB    = 16;
    localparam int TMO_W      = 8;
    localparam int CNT_W      = 16;
    localparam int GAP_W      = 4;
    localparam int UNIT_TICKS = 10;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } coal_state_e;

    typedef struct packed {
        logic             ack;
        logic             arm;
        logic             mute;
        logic [TMO_W-1:0] tmo;
        logic [CNT_W-1:0] cnt;
    } db_cmd_t;

endpackage

// File: rtl/coal_db_decode.sv
module coal_db_decode
    import irq_coal_pkg::*;
(
    input  logic            we_i,
    input  logic [DB_W-1:0] data_i,
    output db_cmd_t         cmd_o
);

    logic tmo_zero;
    wire  unused_rsvd = ^data_i[TMO_LSB+TMO_W+5:TMO_LSB+TMO_W];

    always_comb begin
        tmo_zero   = (data_i[TMO_LSB +: TMO_W] == '0);
        cmd_o.tmo  = data_i[TMO_LSB +: TMO_W];
        cmd_o.cnt  = data_i[CNT_W-1:0];
        cmd_o.ack  = we_i & data_i[ACK_BIT];
        cmd_o.arm  = cmd_o.ack & ~tmo_zero;
        // acknowledge outranks disable when both command bits are set
        cmd_o.mute = (cmd_o.ack & tmo_zero)
                   | (we_i & ~data_i[ACK_BIT] & data_i[OFF_BIT]);
    end

endmodule

// File: rtl/coal_downtimer.sv
module coal_downtimer #(
    parameter int PERIOD = 2,
    parameter int VAL_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [VAL_W-1:0] load_val_i,
    output logic             zero_o
);

    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    logic [PW-1:0]    pre_q;
    logic [VAL_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            left_q <= '0;
        end else if (load_i) begin
            pre_q  <= '0;
            left_q <= load_val_i;
        end else if (left_q != '0) begin
            if (pre_q == LAST) begin
                pre_q  <= '0;
                left_q <= left_q - 1'b1;
            end else begin
                pre_q  <= pre_q + 1'b1;
            end
        end
    end

    assign zero_o = (left_q == '0);

endmodule

// File: rtl/coal_event_ctr.sv
module coal_event_ctr
    import irq_coal_pkg::*;
#(
    parameter int THRESH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             ack_i,
    input  logic [CNT_W-1:0] ack_cnt_i,
    output logic             nonzero_o,
    output logic             reached_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] THR_V   = CNT_W'(THRESH);

    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] after_ack;
    logic [CNT_W-1:0] pend_d;

    always_comb begin
        if (ack_i && (ack_cnt_i >= pend_q)) begin
            after_ack = '0;
        end else if (ack_i) begin
            after_ack = pend_q - ack_cnt_i;
        end else begin
            after_ack = pend_q;
        end
        if (evt_i && (after_ack != CNT_MAX)) begin
            pend_d = after_ack + 1'b1;
        end else begin
            pend_d = after_ack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign nonzero_o = (pend_q != '0);
    assign reached_o = (pend_q >= THR_V);

endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
    import irq_coal_pkg::*;
#(
    parameter int TICK_DIV = 62,
    parameter bit IS_RX    = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_i,
    input  logic            db_we_i,
    input  logic [DB_W-1:0] db_data_i,
    output logic            irq_o
);

    localparam int UNIT_CLKS = TICK_DIV * UNIT_TICKS;
    localparam int PKT_THR   = IS_RX ? 6 : 12;
    localparam int PKT_GAP   = IS_RX ? 3 : 15;
    localparam logic [GAP_W-1:0] GAP_V = GAP_W'(PKT_GAP);

    db_cmd_t     cmd;
    coal_state_e state_q;
    coal_state_e state_d;
    logic        coal_zero;
    logic        gap_zero;
    logic        pend_nz;
    logic        pend_thr;
    logic        fire;

    coal_db_decode u_decode (
        .we_i   (db_we_i),
        .data_i (db_data_i),
        .cmd_o  (cmd)
    );

    coal_event_ctr #(.THRESH(PKT_THR)) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .ack_i     (cmd.ack),
        .ack_cnt_i (cmd.cnt),
        .nonzero_o (pend_nz),
        .reached_o (pend_thr)
    );

    coal_downtimer #(.PERIOD(UNIT_CLKS), .VAL_W(TMO_W)) u_coal_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cmd.arm),
        .load_val_i (cmd.tmo),
        .zero_o     (coal_zero)
    );

    coal_downtimer #(.PERIOD(TICK_DIV), .VAL_W(GAP_W)) u_gap_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (evt_i),
        .load_val_i (GAP_V),
        .zero_o     (gap_zero)
    );

    assign fire = (pend_nz && coal_zero) || (pend_thr && gap_zero);

    // next-state: FIRE inside ARMED, doorbell ARM / MUTE override everything
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = ST_OFF;
            ST_ARMED: if (fire) state_d = ST_FIRED;
            ST_FIRED: state_d = ST_FIRED;
            default:  state_d = ST_OFF;
        endcase
        if (cmd.arm) begin
            state_d = ST_ARMED;
        end else if (cmd.mute) begin
            state_d = ST_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == ST_FIRED);
    end

endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk (
    input logic clk,
    input logic rst_n,
    input logic db_we,
    input logic db_ack,
    input logic db_off,
    input logic irq
);

    // R3
    ack_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_we && db_ack) |=> !irq);

    // R9
    disable_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_we && !db_ack && db_off) |=> !irq);

    // R8
    irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !db_we) |=> irq);

    // R2
    rise_not_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$past(db_we));

endmodule

bind irq_coalesce irq_coalesce_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .db_we  (db_we_i),
    .db_ack (db_data_i[31]),
    .db_off (db_data_i[30]),
    .irq    (irq_o)
);

// File: tb/irq_coalesce_bench.sv
module irq_coalesce_bench;

    localparam int TB_TICK = 2;
    localparam int UNIT    = TB_TICK * 10;
    localparam int THR     = 6;
    localparam int GAP     = 3;
    localparam int NROWS   = 7;
    localparam int ROW_EVT [NROWS] = '{1, 3, 5, 0, 6, 9, 2};
    localparam int ROW_TMO [NROWS] = '{1, 2, 4, 2, 3, 1, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0;
    logic        db_we = 1'b0;
    logic [31:0] db_data = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_coalesce #(.TICK_DIV(TB_TICK), .IS_RX(1'b1)) u_irq_coalesce (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .db_we_i   (db_we),
        .db_data_i (db_data),
        .irq_o     (irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic db_write(input logic [31:0] v);
        @(negedge clk);
        db_we   = 1'b1;
        db_data = v;
        @(negedge clk);
        db_we   = 1'b0;
        db_data = '0;
    endtask

    task automatic send_events(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            evt = 1'b1;
        end
        @(negedge clk);
        evt = 1'b0;
    endtask

    // first cycle index (0 = now) at which irq is high, -1 if none
    task automatic scan_high(input int limit, output int first);
        first = -1;
        for (int n = 0; n <= limit; n++) begin
            if (irq === 1'b1 && first < 0) first = n;
            if (n < limit) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int first;
        int exp;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R1 reset", int'(irq), 0);
        send_events(10);
        repeat (30) @(negedge clk);
        chk(irq == 1'b0, "R1 events while off", int'(irq), 0);

        // table: events sent while off, then arm with a timeout
        for (int r = 0; r < NROWS; r++) begin
            db_write(32'h8000_FFFF);
            send_events(ROW_EVT[r]);
            repeat (8) @(negedge clk);
            db_write({8'h80, 8'(ROW_TMO[r]), 16'h0000});
            if (ROW_EVT[r] == 0 || ROW_TMO[r] == 0) exp = -1;
            else if (ROW_EVT[r] >= THR) exp = 1;
            else exp = ROW_TMO[r] * UNIT + 1;
            scan_high((ROW_TMO[r] == 0) ? 40 : ROW_TMO[r] * UNIT + 10, first);
            chk(first == exp, "R3 R11 table row fire cycle", first, exp);
        end

        // R4 saturating acknowledge, then R5 late event after expiry
        db_write(32'h8000_FFFF);
        send_events(2);
        db_write(32'h8001_0005);
        scan_high(40, first);
        chk(first == -1, "R4 saturated ack no fire", first, -1);
        send_events(1);
        chk(irq == 1'b0, "R5 not same cycle", int'(irq), 0);
        @(negedge clk);
        chk(irq == 1'b1, "R5 fire after late event", int'(irq), 1);

        // R6 inter-packet gap path
        db_write(32'h8000_FFFF);
        db_write(32'h80FF_0000);
        send_events(THR);
        scan_high(20, first);
        chk(first == GAP * TB_TICK + 1, "R6 gap fire cycle", first, GAP * TB_TICK + 1);

        // R7 late event inside the gap restarts it
        db_write(32'h8000_FFFF);
        db_write(32'h80FF_0000);
        send_events(THR);
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R7 quiet inside gap", int'(irq), 0);
        send_events(1);
        scan_high(20, first);
        chk(first == GAP * TB_TICK + 1, "R7 restarted gap", first, GAP * TB_TICK + 1);

        // R8 hold, R2 ignored write and acknowledge priority
        send_events(5);
        chk(irq == 1'b1, "R8 holds through events", int'(irq), 1);
        db_write(32'h0000_00FF);
        repeat (5) @(negedge clk);
        chk(irq == 1'b1, "R2 no-command write ignored", int'(irq), 1);
        db_write(32'hC003_0000);
        chk(irq == 1'b0, "R2 both bits quiets", int'(irq), 0);
        @(negedge clk);
        chk(irq == 1'b1, "R2 ack wins over disable", int'(irq), 1);

        // R9 disable
        db_write(32'h4000_0000);
        chk(irq == 1'b0, "R9 disable drops irq", int'(irq), 0);
        scan_high(50, first);
        chk(first == -1, "R9 stays off", first, -1);

        // R10 zero-timeout acknowledge
        db_write(32'h8001_0000);
        scan_high(5, first);
        chk(first == 1, "R10 setup fire", first, 1);
        db_write(32'h8000_000C);
        chk(irq == 1'b0, "R10 zero timeout drops irq", int'(irq), 0);
        scan_high(30, first);
        chk(first == -1, "R10 stays off", first, -1);
        db_write(32'h8001_0000);
        scan_high(40, first);
        chk(first == -1, "R10 count was acknowledged", first, -1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule